// File: doc/BRIEF.md
# SPI Clock Divisor Best-Fit Search

This block picks the SPI clock divider setting that comes closest to a requested bit rate without going over it. The divider is built from two stages: a power-of-two pre-scaler selected by a 3-bit index and a small integer scaler from 1 to 15. The block is given the input clock frequency and the wanted rate on a start pulse. It then tries every pre-scaler index in turn and returns the best pair, packed into the 8-bit field layout that a divider configuration register expects.

For each pre-scaler index the scaler is the smallest integer that keeps the output rate at or below the request. The achieved rate comes from a second division. Both divisions run one after the other on a single shared restoring divider that yields one quotient bit per cycle. A complete search takes a few hundred cycles. A request of zero finishes at once.

Top module: `spi_div_search`

## Requirements
- R1: Pre-scaler indices p are tried from 0 up to NPRE-1. For each p the candidate scaler is ceil(floor(fclk / 2^p) / req).
- R2: A candidate whose scaler is 0 or greater than SC_MAX (15) is discarded. A successful result always has a scaler from 1 to 15.
- R3: The achieved rate is floor(fclk / (scaler * 2^p)) and never exceeds req. The reported error is req minus the achieved rate.
- R4: The running best error starts at req. A candidate replaces the best only if its error is strictly smaller, so on a tie the lower p is kept.
- R5: If no candidate was accepted (best scaler and best p both 0), fail_o is 1, scaler_o, pre_o, rate_o and field_o are 0, and err_o equals req.
- R6: field_o bits [7:6] hold p[2:1], bit 5 is 0, bit 4 holds p[0], and bits [3:0] hold the scaler.
- R7: A request of 0 fails with no division. done_o rises at most two clock edges after the start edge, with err_o equal to 0.
- R8: start_i is ignored while busy_o is 1. A second start during a search does not change that search's result.
- R9: done_o is a one-cycle pulse. busy_o is 1 from the edge after start until done_o. The result outputs keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search, sampled while idle |
| fclk_i | input | 32 | Input clock frequency |
| req_i | input | 32 | Requested SPI rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | No valid setting found |
| field_o | output | 8 | Packed divider field |
| scaler_o | output | 4 | Chosen scaler |
| pre_o | output | 3 | Chosen pre-scaler index |
| rate_o | output | 32 | Achieved rate |
| err_o | output | 32 | req minus achieved rate |

## Verification
The bench builds the block with its default parameters: 32-bit operands, eight pre-scaler indices and a scaler limit of 15. With these values the highest index (7) is reachable, so both bits of the upper field pair get exercised. The scaler limit is also small enough that a fast input clock with a slow request fails every candidate. The chosen cases cover an exact match that ties across indices, odd and high indices, a request above the input clock, an all-rejected search and a zero request. A set of mixed operand pairs is also checked against an independent model of the search.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAND,
    ST_SCL,
    ST_RDIV,
    ST_RATE,
    ST_FIN
  } srch_st_e;
endpackage

// File: rtl/div_unit.sv
// Restoring divider, one quotient bit per cycle; den_i must be nonzero.
module div_unit #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0]  rem_q, quo_q, den_q, num_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W:0]    shf, dif;

  assign shf = {rem_q, quo_q[W-1]};
  assign dif = shf - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        num_q <= num_i;
        den_q <= den_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        if (!dif[W]) begin
          rem_q <= dif[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shf[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R3
  div_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((2*W)'(quo_q) * (2*W)'(den_q) + (2*W)'(rem_q) == (2*W)'(num_q)) && (rem_q < den_q));
endmodule

// File: rtl/prs_pack.sv
module prs_pack #(
  parameter int P_W  = 3,
  parameter int SC_W = 4,
  localparam int FW  = P_W + SC_W + 1
) (
  input  logic [P_W-1:0]  pre_i,
  input  logic [SC_W-1:0] sc_i,
  output logic [FW-1:0]   field_o
);
  generate
    if (P_W == 3 && SC_W == 4) begin : g_split
      // low index bit sits below the gap, upper pair at the top
      assign field_o = {pre_i[2:1], 1'b0, pre_i[0], sc_i};
    end else begin : g_flat
      assign field_o = {pre_i, 1'b0, sc_i};
    end
  endgenerate
endmodule

// File: rtl/spi_div_search.sv
module spi_div_search
  import spi_div_pkg::*;
#(
  parameter int W      = 32,
  parameter int NPRE   = 8,
  parameter int SC_MAX = 15,
  localparam int P_W   = $clog2(NPRE),
  localparam int SC_W  = $clog2(SC_MAX + 1),
  localparam int FW    = P_W + SC_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [W-1:0]    fclk_i,
  input  logic [W-1:0]    req_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [FW-1:0]   field_o,
  output logic [SC_W-1:0] scaler_o,
  output logic [P_W-1:0]  pre_o,
  output logic [W-1:0]    rate_o,
  output logic [W-1:0]    err_o
);
  srch_st_e        st_q;
  logic [P_W-1:0]  p_q, best_p_q;
  logic [SC_W-1:0] cand_sc_q, best_sc_q;
  logic [W-1:0]    fclk_q, req_q, best_err_q, best_rate_q;
  logic            done_q, fail_q;

  logic            dv_go, dv_done;
  logic [W-1:0]    dv_num, dv_den, dv_q, dv_r;
  logic [W:0]      ceil_sc;
  logic            skip;
  logic [W-1:0]    err_c;
  logic            last_p;

  always_comb begin
    dv_go  = 1'b0;
    dv_num = fclk_q >> p_q;
    dv_den = req_q;
    if (st_q == ST_CAND) begin
      dv_go = 1'b1;
    end else if (st_q == ST_RDIV) begin
      dv_go  = 1'b1;
      dv_num = fclk_q;
      dv_den = W'(cand_sc_q) << p_q;
    end
  end

  div_unit #(.W(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (dv_go),
    .num_i  (dv_num),
    .den_i  (dv_den),
    .done_o (dv_done),
    .quo_o  (dv_q),
    .rem_o  (dv_r)
  );

  assign ceil_sc = {1'b0, dv_q} + (W+1)'(dv_r != '0);
  assign skip    = (ceil_sc == '0) || (ceil_sc > (W+1)'(SC_MAX));
  assign err_c   = req_q - dv_q;
  assign last_p  = (p_q == P_W'(NPRE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      p_q         <= '0;
      cand_sc_q   <= '0;
      best_p_q    <= '0;
      best_sc_q   <= '0;
      best_err_q  <= '0;
      best_rate_q <= '0;
      fclk_q      <= '0;
      req_q       <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          fclk_q      <= fclk_i;
          req_q       <= req_i;
          p_q         <= '0;
          best_p_q    <= '0;
          best_sc_q   <= '0;
          best_rate_q <= '0;
          best_err_q  <= req_i;
          fail_q      <= 1'b0;
          st_q        <= (req_i == '0) ? ST_FIN : ST_CAND;
        end
        ST_CAND: st_q <= ST_SCL;
        ST_SCL: if (dv_done) begin
          if (skip) begin
            if (last_p) st_q <= ST_FIN;
            else begin
              p_q  <= p_q + 1'b1;
              st_q <= ST_CAND;
            end
          end else begin
            cand_sc_q <= ceil_sc[SC_W-1:0];
            st_q      <= ST_RDIV;
          end
        end
        ST_RDIV: st_q <= ST_RATE;
        ST_RATE: if (dv_done) begin
          if (err_c < best_err_q) begin
            best_err_q  <= err_c;
            best_rate_q <= dv_q;
            best_sc_q   <= cand_sc_q;
            best_p_q    <= p_q;
          end
          if (last_p) st_q <= ST_FIN;
          else begin
            p_q  <= p_q + 1'b1;
            st_q <= ST_CAND;
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          fail_q <= (best_sc_q == '0) && (best_p_q == '0);
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  prs_pack #(.P_W(P_W), .SC_W(SC_W)) u_pack (
    .pre_i   (best_p_q),
    .sc_i    (best_sc_q),
    .field_o (field_o)
  );

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign scaler_o = best_sc_q;
  assign pre_o    = best_p_q;
  assign rate_o   = best_rate_q;
  assign err_o    = best_err_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(req_q) && $stable(fclk_q)));
  // R3
  rate_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (rate_o <= req_q));
  // R2
  scaler_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (scaler_o != '0) && (32'(scaler_o) <= 32'(SC_MAX)));
  // R5
  fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (rate_o == '0) && (err_o == req_q) && (field_o == '0));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(field_o) && $stable(rate_o) && $stable(err_o)));
endmodule

// File: tb/sim_spi_div_search.sv
module sim_spi_div_search;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] fclk_i = '0;
  logic [31:0] req_i = '0;
  logic        busy_o, done_o, fail_o;
  logic [7:0]  field_o;
  logic [3:0]  scaler_o;
  logic [2:0]  pre_o;
  logic [31:0] rate_o, err_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  spi_div_search u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fclk_i(fclk_i), .req_i(req_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .field_o(field_o),
    .scaler_o(scaler_o), .pre_o(pre_o), .rate_o(rate_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // independent model of the search
  task automatic model(input longint f, input longint r, output int e_sc, output int e_p,
                       output longint e_rate, output longint e_err, output bit e_fail);
    longint best_err;
    e_sc = 0; e_p = 0; e_rate = 0; best_err = r;
    if (r != 0) begin
      for (int p = 0; p < 8; p++) begin
        longint base = f / (64'd1 << p);
        longint sc   = (base + r - 1) / r;
        if (sc == 0 || sc > 15) continue;
        begin
          longint ach = f / (sc * (64'd1 << p));
          longint e   = r - ach;
          if (e < best_err) begin
            best_err = e; e_sc = int'(sc); e_p = p; e_rate = ach;
          end
        end
      end
    end
    e_err  = best_err;
    e_fail = (e_sc == 0 && e_p == 0);
  endtask

  task automatic launch(input logic [31:0] f, input logic [31:0] r);
    @(negedge clk_i);
    fclk_i = f; req_i = r; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int ncyc);
    ncyc = 1;
    while (!done_o && ncyc < 5000) begin
      @(negedge clk_i);
      ncyc++;
    end
  endtask

  task automatic check_vs_model(input longint f, input longint r, input string rq);
    int e_sc, e_p; longint e_rate, e_err; bit e_fail; logic [7:0] e_fld;
    model(f, r, e_sc, e_p, e_rate, e_err, e_fail);
    e_fld = {e_p[2:1], 1'b0, e_p[0], e_sc[3:0]};
    chk(done_o == 1'b1, rq, "done", done_o, 1);
    chk(fail_o == e_fail, rq, "fail", fail_o, e_fail);
    chk(scaler_o == e_sc[3:0], rq, "scaler", scaler_o, e_sc);
    chk(pre_o == e_p[2:0], rq, "pre", pre_o, e_p);
    chk(rate_o == e_rate[31:0], rq, "rate", rate_o, e_rate);
    chk(err_o == e_err[31:0], rq, "err", err_o, e_err);
    chk(field_o == e_fld, "R6", "field", field_o, e_fld);
  endtask

  task automatic run_case(input logic [31:0] f, input logic [31:0] r, input string rq);
    int n;
    launch(f, r);
    wait_done(n);
    check_vs_model(f, r, rq);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !fail_o, "R9", "idle after reset", {busy_o, done_o, fail_o}, 0);
    chk(field_o == 0 && rate_o == 0 && err_o == 0, "R9", "outputs after reset", field_o, 0);
  endtask

  task automatic t_exact_tie();
    // p=0 sc=10 exact; later indices tie at zero error (R4 keeps p=0)
    run_case(100_000_000, 10_000_000, "R4");
    chk(pre_o == 0 && scaler_o == 10, "R4", "tie keeps lowest p", pre_o, 0);
    chk(field_o == 8'h0A, "R6", "field p0 sc10", field_o, 8'h0A);
  endtask

  task automatic t_high_index();
    // p=4 sc=13 best; field 0x8D
    run_case(200_000_000, 1_000_000, "R1");
    chk(field_o == 8'h8D, "R6", "field p4 sc13", field_o, 8'h8D);
    chk(rate_o == 961538, "R3", "rate p4", rate_o, 961538);
  endtask

  task automatic t_odd_index();
    // p=0 sc=30 skipped, p=1 sc=15 exact
    run_case(30_000_000, 1_000_000, "R2");
    chk(field_o == 8'h1F, "R6", "field p1 sc15", field_o, 8'h1F);
  endtask

  task automatic t_fast_req();
    run_case(1000, 5000, "R3");
    chk(scaler_o == 1 && err_o == 4000, "R3", "req above fclk", err_o, 4000);
  endtask

  task automatic t_all_reject();
    run_case(1_000_000_000, 1000, "R5");
    chk(fail_o && err_o == 1000 && field_o == 0, "R5", "all rejected", err_o, 1000);
  endtask

  task automatic t_zero_req();
    int n;
    launch(50_000_000, 0);
    wait_done(n);
    chk(n <= 2, "R7", "zero request latency", n, 2);
    chk(done_o && fail_o && err_o == 0, "R7", "zero request fails", fail_o, 1);
  endtask

  task automatic t_pulse_hold();
    logic [7:0] fld; logic [31:0] rt;
    run_case(48_000_000, 1_500_000, "R9");
    fld = field_o; rt = rate_o;
    @(negedge clk_i);
    chk(!done_o, "R9", "done one cycle", done_o, 0);
    repeat (5) @(negedge clk_i);
    chk(field_o == fld && rate_o == rt && !busy_o, "R9", "result held", field_o, fld);
  endtask

  task automatic t_busy_ignore();
    int n;
    launch(200_000_000, 1_000_000);
    chk(busy_o, "R9", "busy after start", busy_o, 1);
    repeat (20) @(negedge clk_i);
    fclk_i = 30_000_000; req_i = 1_000_000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(n);
    check_vs_model(200_000_000, 1_000_000, "R8");
  endtask

  task automatic t_sweep();
    logic [31:0] fs [6] = '{32'd125_000_000, 32'd33_333_333, 32'd7, 32'd4_000_000_000, 32'd166_000_000, 32'd25_000_000};
    logic [31:0] rs [6] = '{32'd3_000_000, 32'd700_000, 32'd1, 32'd123_456_789, 32'd2_500_000, 32'd30_000};
    for (int i = 0; i < 6; i++) run_case(fs[i], rs[i], "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_exact_tie();
    t_high_index();
    t_odd_index();
    t_fast_req();
    t_all_reject();
    t_zero_req();
    t_pulse_hold();
    t_busy_ignore();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG_CYC);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WDOG_CYC);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule